// File: doc/BRIEF.md
# Multiplexed LCD Common Scan Sequencer

This block decides which common (row) electrode of a multiplexed character LCD is driven with the select level during each row period. It drives up to 17 commons. Each pulse on `row_tick` moves the scan to the next row. The block outputs a one-hot vector in which bit k stands for common k+1, and a flag that toggles once per frame so the analog stage can alternate drive polarity. A second flag marks the row period that belongs to the arbitrator (icon) line, which lets the segment path fetch arbitrator data for that row.

Three mode inputs set the scan:
- A duty code sets how many commons make up a frame: 9, 12 or 17.
- A direction pin sets whether the scan runs upward or downward through the commons.
- A placement bit moves the arbitrator line to the opposite end of the active commons.

The arbitrator row always takes the last time slot of a frame. The mode inputs are sampled while reset is held and at the tick that ends a frame. A change made part-way through a frame therefore never breaks a frame.

Top module: `com_scan_seq`

## Requirements
- R1: Out of reset, `com_sel` has exactly one bit set at all times.
- R2: Duty code 0 gives 9 rows per frame, code 1 gives 12, and codes 2 and 3 give 17. Commons at or beyond the row count (bits n..16 of `com_sel`) are never selected.
- R3: With `scan_rev`=0 and `arb_lead`=0, the rows select COM1, COM2, ... COMn in order. The arbitrator row is on COMn.
- R4: With `scan_rev`=0 and `arb_lead`=1, the character rows select COM2 up to COMn in order. The last slot (the arbitrator row) selects COM1.
- R5: With `scan_rev`=1 and `arb_lead`=0, the rows select COMn down to COM1. The arbitrator row is on COM1.
- R6: With `scan_rev`=1 and `arb_lead`=1, the character rows select COM(n-1) down to COM1. The last slot (the arbitrator row) selects COMn.
- R7: `arb_row` is 1 exactly during the last row slot (slot n-1) of each frame and 0 otherwise.
- R8: `frame_flip` is 0 after reset. It inverts on the tick that ends a frame and holds on every other tick.
- R9: The mode inputs are taken only while `rst` is high or at the tick that ends a frame. A change in the middle of a frame has no effect on the rows left in that frame. The new frame then starts at slot 0 of the new mode.
- R10: While `row_tick` is low, `com_sel`, `arb_row` and `frame_flip` hold their values.
- R11: A synchronous reset (`rst`=1 at a clock edge) places the scan on slot 0 of the mode present at its inputs, with `frame_flip`=0. This holds even when reset arrives mid-frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_tick | input | 1 | One-cycle pulse that advances to the next row |
| duty_sel | input | 2 | Duty code: 0 = 9 rows, 1 = 12 rows, 2 or 3 = 17 rows |
| scan_rev | input | 1 | 0 = scan upward from COM1, 1 = scan downward |
| arb_lead | input | 1 | Moves the arbitrator line to the opposite end |
| com_sel | output | 17 | One-hot common select, bit k = COM(k+1) |
| arb_row | output | 1 | High during the arbitrator row slot |
| frame_flip | output | 1 | Frame alternation flag |

## Verification
The bench steps all four duty codes through every combination of direction and placement. It runs at least one full frame in each combination, so the four orderings are separated from each other and from the three row counts. Mode inputs are changed part-way through frames to show that they are deferred to the frame boundary. Idle gaps between ticks show that the outputs hold while `row_tick` is low. A second reset applied mid-frame shows that the scan restarts on slot 0 of the current mode. A reference model in the bench predicts every row, and a scoreboard checks the select vector, the arbitrator flag and the frame flag against it.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

    localparam int NUM_COM    = 17;
    localparam int ROWS_SHORT = 9;
    localparam int ROWS_MID   = 12;
    localparam int ROWS_FULL  = 17;
    localparam int CNT_W      = $clog2(NUM_COM + 1);

    typedef logic [CNT_W-1:0] row_t;

    typedef enum logic [1:0] {
        DUTY_SHORT = 2'd0,
        DUTY_MID   = 2'd1,
        DUTY_FULL  = 2'd2,
        DUTY_ALT   = 2'd3
    } duty_e;

    typedef struct packed {
        duty_e duty;
        logic  rev;
        logic  arb_lead;
    } scan_mode_t;

    // Rows per frame for a duty code
    function automatic row_t rows_of(duty_e d);
        case (d)
            DUTY_SHORT: return row_t'(ROWS_SHORT);
            DUTY_MID:   return row_t'(ROWS_MID);
            default:    return row_t'(ROWS_FULL);
        endcase
    endfunction

    // Zero-based common index driven in time slot idx
    function automatic row_t com_of(row_t idx, row_t n, logic rev, logic lead);
        row_t last;
        last = n - row_t'(1);
        if (idx == last)
            return (rev ^ lead) ? row_t'(0) : last;
        if (!rev)
            return lead ? idx + row_t'(1) : idx;
        return (lead ? last - row_t'(1) : last) - idx;
    endfunction

endpackage

// File: rtl/com_mode_latch.sv
module com_mode_latch
    import com_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] duty_in,
    input  logic       rev_in,
    input  logic       lead_in,
    output scan_mode_t mode
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            mode.duty     <= duty_e'(duty_in);
            mode.rev      <= rev_in;
            mode.arb_lead <= lead_in;
        end
    end

endmodule

// File: rtl/com_row_counter.sv
module com_row_counter
    import com_scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  row_t rows,
    output row_t idx,
    output logic frame,
    output logic wrap
);

    assign wrap = tick && (idx == rows - row_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            frame <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                idx   <= '0;
                frame <= ~frame;
            end else begin
                idx   <= idx + row_t'(1);
            end
        end
    end

endmodule

// File: rtl/com_onehot_decode.sv
module com_onehot_decode
    import com_scan_pkg::*;
#(
    parameter int WIDTH = NUM_COM
) (
    input  row_t             target,
    input  row_t             rows,
    output logic [WIDTH-1:0] sel
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_com
        assign sel[k] = (target == row_t'(k)) && (row_t'(k) < rows);
    end

endmodule

// File: rtl/com_scan_seq.sv
module com_scan_seq
    import com_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               row_tick,
    input  logic [1:0]         duty_sel,
    input  logic               scan_rev,
    input  logic               arb_lead,
    output logic [NUM_COM-1:0] com_sel,
    output logic               arb_row,
    output logic               frame_flip
);

    scan_mode_t mode_q;
    row_t       rows;
    row_t       slot;
    row_t       target;
    logic       frame_end;

    com_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_end),
        .duty_in (duty_sel),
        .rev_in  (scan_rev),
        .lead_in (arb_lead),
        .mode    (mode_q)
    );

    assign rows = rows_of(mode_q.duty);

    com_row_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (row_tick),
        .rows  (rows),
        .idx   (slot),
        .frame (frame_flip),
        .wrap  (frame_end)
    );

    assign target  = com_of(slot, rows, mode_q.rev, mode_q.arb_lead);
    assign arb_row = (slot == rows - row_t'(1));

    com_onehot_decode #(.WIDTH(NUM_COM)) u_dec (
        .target (target),
        .rows   (rows),
        .sel    (com_sel)
    );

endmodule

// File: rtl/com_scan_seq_chk.sv
module com_scan_seq_chk
    import com_scan_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               row_tick,
    input logic [NUM_COM-1:0] com_sel,
    input logic               arb_row,
    input logic               frame_flip,
    input scan_mode_t         mode
);

    int                 n_rows;
    logic [NUM_COM-1:0] quiet_mask;

    always_comb begin
        case (mode.duty)
            DUTY_SHORT: n_rows = ROWS_SHORT;
            DUTY_MID:   n_rows = ROWS_MID;
            default:    n_rows = ROWS_FULL;
        endcase
        for (int k = 0; k < NUM_COM; k++) quiet_mask[k] = (k >= n_rows);
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(com_sel) == 1);                                   // R1

    AST_QUIET_COMMONS: assert property (@(posedge clk) disable iff (rst)
        (com_sel & quiet_mask) == '0);                               // R2

    AST_ARB_END: assert property (@(posedge clk) disable iff (rst)
        arb_row |-> ((mode.rev ^ mode.arb_lead) ? com_sel[0] : com_sel[n_rows-1])); // R7

    AST_FRAME_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (row_tick && arb_row) |=> (frame_flip != $past(frame_flip))); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (row_tick && !arb_row) |=> $stable(frame_flip));             // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !row_tick |=> ($stable(com_sel) && $stable(arb_row)));       // R10

endmodule

bind com_scan_seq com_scan_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_tick   (row_tick),
    .com_sel    (com_sel),
    .arb_row    (arb_row),
    .frame_flip (frame_flip),
    .mode       (mode_q)
);

// File: tb/sim_com_scan_seq.sv
module sim_com_scan_seq;

    localparam int NC = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          row_tick = 1'b0;
    logic [1:0]    duty_sel = 2'd2;
    logic          scan_rev = 1'b0;
    logic          arb_lead = 1'b0;
    logic [NC-1:0] com_sel;
    logic          arb_row;
    logic          frame_flip;

    always #5 clk = ~clk;

    com_scan_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .row_tick   (row_tick),
        .duty_sel   (duty_sel),
        .scan_rev   (scan_rev),
        .arb_lead   (arb_lead),
        .com_sel    (com_sel),
        .arb_row    (arb_row),
        .frame_flip (frame_flip)
    );

    typedef struct {
        logic [NC-1:0] sel;
        bit            arb;
        bit            frm;
        int            n;
        string         tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    int m_n, m_i;
    bit m_rev, m_as, m_frame;

    function automatic int duty_rows(logic [1:0] d);
        if (d == 2'd0) return 9;
        if (d == 2'd1) return 12;
        return 17;
    endfunction

    function automatic int exp_com(int i, int n, bit rev, bit as_b);
        if (i == n - 1) begin
            case ({rev, as_b})
                2'b00:   return n - 1;
                2'b01:   return 0;
                2'b10:   return 0;
                default: return n - 1;
            endcase
        end
        case ({rev, as_b})
            2'b00:   return i;
            2'b01:   return i + 1;
            2'b10:   return n - 1 - i;
            default: return n - 2 - i;
        endcase
    endfunction

    function automatic string order_tag(bit rev, bit as_b);
        case ({rev, as_b})
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_model();
        m_n   = duty_rows(duty_sel);
        m_rev = scan_rev;
        m_as  = arb_lead;
    endtask

    task automatic push_exp(string extra);
        exp_t e;
        e.sel = '0;
        e.sel[exp_com(m_i, m_n, m_rev, m_as)] = 1'b1;
        e.arb = (m_i == m_n - 1);
        e.frm = m_frame;
        e.n   = m_n;
        e.tag = {order_tag(m_rev, m_as), extra};
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    always @(chk_ev) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check($countones(com_sel) == 1, "R1 one-hot", 32'(com_sel), 32'(e.sel));
            check((com_sel >> e.n) == '0, "R2 quiet commons", 32'(com_sel), 32'(0));
            check(com_sel == e.sel, {e.tag, " com_sel"}, 32'(com_sel), 32'(e.sel));
            check(arb_row == e.arb, {"R7 arb_row", e.tag}, 32'(arb_row), 32'(e.arb));
            check(frame_flip == e.frm, {"R8 frame_flip", e.tag}, 32'(frame_flip), 32'(e.frm));
        end
    end

    task automatic tick_row(int gap, string extra);
        row_tick = 1'b1;
        @(negedge clk);
        row_tick = 1'b0;
        if (m_i == m_n - 1) begin
            m_i = 0;
            m_frame = ~m_frame;
            load_model();
        end else begin
            m_i++;
        end
        repeat (gap) @(negedge clk);
        push_exp(extra);
    endtask

    task automatic do_reset(string extra);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        load_model();
        m_i = 0;
        m_frame = 1'b0;
        push_exp(extra);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(" R11 reset state");

        for (int d = 0; d < 4; d++) begin
            for (int r = 0; r < 2; r++) begin
                for (int a = 0; a < 2; a++) begin
                    // advance a few rows, then change mode mid-frame
                    tick_row(0, "");
                    duty_sel = 2'(d);
                    scan_rev = 1'(r);
                    arb_lead = 1'(a);
                    tick_row(0, " R9 deferred");
                    while (m_i != 0) tick_row(0, " R9");
                    for (int k = 0; k < m_n; k++)
                        tick_row((k % 5 == 2) ? 3 : 0, (k % 5 == 2) ? " R10 idle" : "");
                end
            end
        end

        // mid-frame reset onto a new mode
        tick_row(0, "");
        tick_row(0, "");
        duty_sel = 2'd0;
        scan_rev = 1'b1;
        arb_lead = 1'b1;
        do_reset(" R11 mid-frame reset");
        for (int k = 0; k < 10; k++) tick_row(0, " R11");

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule